// File: doc/BRIEF.md
# Reset and NMI Request Controller

This block collects every source that may restart or interrupt a small CPU system and turns them into two outputs: a stretched CPU reset and a one-clock NMI pulse. Two handshake lines from a host serial bridge act as remote reset triggers. Each line has its own 2-bit trigger mode, so the host can pulse a line without restarting the target, or restart it on a chosen edge.

The remaining sources are set through one 8-bit control register:
- a software reset bit;
- a watchdog that a write strobe on the ID register services;
- a real-time-clock event that can be steered either to reset or to NMI;
- a debounced user pushbutton that may raise NMI.

A write strobe on the version register forces a full reset, which also clears the control register. Power-on reset comes from outside on `rst_n`.

Top module: `rst_nmi_ctrl`

## Requirements
- R1: After `rst_n` is released, `cpu_rst_o` and `nmi_o` are 0 and `ctl_o` reads 8'h00.
- R2: A `ctl_wr_i` strobe loads `ctl_wdata_i` into the control register, visible on `ctl_o` one clock later. The bit fields are:
  - [1:0] mode of line A;
  - [3:2] mode of line B;
  - [4] software reset;
  - [5] watchdog enable;
  - [6] RTC-to-NMI select;
  - [7] button NMI enable.
- R3: Each handshake line is synchronised by two flip-flops, and its mode decides its effect:
  - 00 ignores the line;
  - 01 requests reset on a falling edge;
  - 10 requests reset on a rising edge;
  - 11 requests reset on either edge.
  
  `cpu_rst_o` rises on the third clock edge after the line changes.
- R4: Any reset request drives `cpu_rst_o` high for exactly RST_CYCLES clocks (default 16). A new request while the reset is active reloads the full count.
- R5: Writing 1 to bit 4 raises `cpu_rst_o` on the second clock edge after the write. The bit reads 0 once the reset has started, and the mode bits are kept.
- R6: The watchdog counts only while bit 5 is 1.
  - With no `id_wr_i` strobe, `cpu_rst_o` rises WDOG_CYCLES clocks after the enabling write.
  - Each `id_wr_i` strobe restarts the count.
  - Any reset clears bit 5.
- R7: A rising edge on `rtc_evt_i` has the same 3-clock latency as R3. It requests a reset when bit 6 is 0, and an NMI pulse (with no reset) when bit 6 is 1.
- R8: The button is synchronised and must hold a new level for DEB_CYCLES clocks before that level is accepted.
  - With bit 7 set, an accepted press (0 to 1) raises `nmi_o` DEB_CYCLES+2 clock edges after the button input rises.
  - A release, a press with bit 7 clear, and a press shorter than the filter produce no NMI.
- R9: A `ver_wr_i` strobe raises `cpu_rst_o` at the next clock edge and clears the whole control register to 8'h00.
- R10: `nmi_o` is never high for two cycles in a row. NMI sources that hit the same cycle give one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| hs_a_i | input | 1 | Host handshake line A (asynchronous) |
| hs_b_i | input | 1 | Host handshake line B (asynchronous) |
| rtc_evt_i | input | 1 | Real-time-clock event line (asynchronous, active high) |
| btn_i | input | 1 | Raw user pushbutton, 1 = pressed |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| id_wr_i | input | 1 | ID register write strobe, services the watchdog |
| ver_wr_i | input | 1 | Version register write strobe, full reset |
| ctl_o | output | 8 | Control register contents |
| cpu_rst_o | output | 1 | Stretched CPU reset, active high |
| nmi_o | output | 1 | One-clock NMI pulse, active high |

## Verification
Two pairs of functions can fall in the same cycle, and the bench drives both.

- **Handshake reset with RTC NMI.** The bench raises handshake line A (mode rising edge) and the RTC line on the same clock, with the RTC steered to NMI. It then expects the start of the reset and the NMI pulse on the very same sample, three edges later.
- **Button NMI with RTC NMI.** The bench presses the button three clocks before raising the RTC line, so that the debounced press and the synchronised RTC edge ask for NMI in one cycle. It then counts exactly one NMI pulse.

// File: rtl/rnc_pkg.sv
package rnc_pkg;

    typedef enum logic [1:0] {
        TRIG_OFF  = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_ANY  = 2'b11
    } trig_e;

    typedef struct packed {
        logic  btn_nmi_en;
        logic  rtc_to_nmi;
        logic  wd_en;
        logic  sw_rst;
        trig_e mode_b;
        trig_e mode_a;
    } ctl_t;

    function automatic logic trig_hit(trig_e m, logic rise, logic fall);
        case (m)
            TRIG_FALL: return fall;
            TRIG_RISE: return rise;
            TRIG_ANY:  return rise | fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rnc_edge_sync.sv
module rnc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], async_i};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise_o = s_q.chain[STAGES-1] & ~s_q.prev;
    assign fall_o = ~s_q.chain[STAGES-1] & s_q.prev;
endmodule

// File: rtl/rnc_debounce.sv
module rnc_debounce #(
    parameter int SYNC   = 2,
    parameter int CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic press_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    typedef struct packed {
        logic [SYNC-1:0] chain;
        logic            stable;
        logic [CW-1:0]   cnt;
    } st_t;

    st_t s_d, s_q;
    logic fresh;
    logic accept;

    always_comb begin
        fresh     = s_q.chain[SYNC-1];
        accept    = (fresh != s_q.stable) && (s_q.cnt == LAST);
        s_d       = s_q;
        s_d.chain = {s_q.chain[SYNC-2:0], raw_i};
        if (fresh == s_q.stable) begin
            s_d.cnt = '0;
        end else if (accept) begin
            s_d.stable = fresh;
            s_d.cnt    = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign press_o = accept & fresh;
endmodule

// File: rtl/rnc_wdog.sv
module rnc_wdog #(
    parameter int CYCLES = 1 << 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic kick_i,
    input  logic clr_i,
    output logic bite_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!en_i || kick_i || clr_i) cnt_d = '0;
        else                          cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign bite_o = en_i && !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/rst_nmi_ctrl.sv
module rst_nmi_ctrl
    import rnc_pkg::*;
#(
    parameter int RST_CYCLES  = 16,
    parameter int WDOG_CYCLES = 1 << 20,
    parameter int DEB_CYCLES  = 50000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hs_a_i,
    input  logic       hs_b_i,
    input  logic       rtc_evt_i,
    input  logic       btn_i,
    input  logic       ctl_wr_i,
    input  logic [7:0] ctl_wdata_i,
    input  logic       id_wr_i,
    input  logic       ver_wr_i,
    output logic [7:0] ctl_o,
    output logic       cpu_rst_o,
    output logic       nmi_o
);
    localparam int RC_W = $clog2(RST_CYCLES + 1);
    localparam logic [RC_W-1:0] RC_LOAD = RC_W'(RST_CYCLES);

    typedef struct packed {
        ctl_t            ctl;
        logic [RC_W-1:0] rcnt;
        logic            nmi;
    } st_t;

    st_t  s_d, s_q;
    logic [2:0] rise, fall;     // 0: line A, 1: line B, 2: RTC
    logic press, bite;
    logic rst_req, nmi_req;
    logic [2:0] src_in;

    assign src_in = {rtc_evt_i, hs_b_i, hs_a_i};

    for (genvar g = 0; g < 3; g++) begin : g_sync
        rnc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .async_i(src_in[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
        );
    end

    rnc_debounce #(.SYNC(SYNC_STAGES), .CYCLES(DEB_CYCLES)) u_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (btn_i),
        .press_o(press)
    );

    rnc_wdog #(.CYCLES(WDOG_CYCLES)) u_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (s_q.ctl.wd_en),
        .kick_i(id_wr_i),
        .clr_i (cpu_rst_o),
        .bite_o(bite)
    );

    always_comb begin
        logic rtc_edge;
        rtc_edge = trig_hit(TRIG_RISE, rise[2], fall[2]);

        rst_req = trig_hit(s_q.ctl.mode_a, rise[0], fall[0])
                | trig_hit(s_q.ctl.mode_b, rise[1], fall[1])
                | s_q.ctl.sw_rst
                | bite
                | (rtc_edge & ~s_q.ctl.rtc_to_nmi)
                | ver_wr_i;
        nmi_req = (rtc_edge & s_q.ctl.rtc_to_nmi)
                | (press & s_q.ctl.btn_nmi_en);

        s_d = s_q;
        if (ctl_wr_i) s_d.ctl = ctl_t'(ctl_wdata_i);
        if (rst_req) begin
            s_d.ctl.sw_rst = 1'b0;
            s_d.ctl.wd_en  = 1'b0;
        end
        if (ver_wr_i) s_d.ctl = '0;

        if (rst_req)               s_d.rcnt = RC_LOAD;
        else if (s_q.rcnt != '0)   s_d.rcnt = s_q.rcnt - 1'b1;

        s_d.nmi = nmi_req & ~s_q.nmi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl_o     = s_q.ctl;
    assign cpu_rst_o = (s_q.rcnt != '0);
    assign nmi_o     = s_q.nmi;
endmodule

// File: rtl/rnc_chk.sv
module rnc_chk #(
    parameter int RST_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ver_wr_i,
    input logic [7:0] ctl_o,
    input logic       cpu_rst_o,
    input logic       nmi_o
);
    logic [15:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_q <= '0;
        else if (!cpu_rst_o) run_q <= '0;
        else if (run_q != 16'hFFFF) run_q <= run_q + 1'b1;
    end

    // R10
    nmi_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |=> !nmi_o);

    // R4
    rst_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_rst_o) |-> (run_q >= 16'(RST_CYCLES)));

    // R6
    self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_o) |-> (!ctl_o[4] && !ctl_o[5]));

    // R5
    sw_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_o[4]) |=> cpu_rst_o);

    // R9
    ver_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ver_wr_i |=> (cpu_rst_o && ctl_o == 8'h00));
endmodule

bind rst_nmi_ctrl rnc_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ver_wr_i (ver_wr_i),
    .ctl_o    (ctl_o),
    .cpu_rst_o(cpu_rst_o),
    .nmi_o    (nmi_o)
);

// File: tb/rst_nmi_ctrl_test.sv
module rst_nmi_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs_a = 1'b0, hs_b = 1'b0, rtc = 1'b0, btn = 1'b0;
    logic       ctl_wr = 1'b0, id_wr = 1'b0, ver_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_o;
    logic       cpu_rst_o, nmi_o;
    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    rst_nmi_ctrl #(.RST_CYCLES(16), .WDOG_CYCLES(64), .DEB_CYCLES(4)) uut (
        .clk(clk), .rst_n(rst_n), .hs_a_i(hs_a), .hs_b_i(hs_b),
        .rtc_evt_i(rtc), .btn_i(btn), .ctl_wr_i(ctl_wr),
        .ctl_wdata_i(ctl_wdata), .id_wr_i(id_wr), .ver_wr_i(ver_wr),
        .ctl_o(ctl_o), .cpu_rst_o(cpu_rst_o), .nmi_o(nmi_o)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic kick();
        id_wr = 1'b1;
        @(negedge clk);
        id_wr = 1'b0;
    endtask

    task automatic set_hs(input int ln, input logic v);
        if (ln == 0) hs_a = v; else hs_b = v;
    endtask

    task automatic idle(input int n, output int hits, output int nm);
        hits = 0; nm = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cpu_rst_o) hits++;
            if (nmi_o) nm++;
        end
    endtask

    // latency in negedges until reset, -1 if none within lim; then length
    task automatic meas_rst(input string req, input int exp_lat, input int lim);
        int lat, len;
        lat = 0;
        while (!cpu_rst_o && lat < lim) begin
            @(negedge clk);
            lat++;
        end
        chk(req, cpu_rst_o ? lat : -1, exp_lat);
        if (cpu_rst_o) begin
            len = 0;
            while (cpu_rst_o && len < 100) begin
                len++;
                @(negedge clk);
            end
            chk("R4", len, 16);
        end
    endtask

    task automatic meas_nmi(input string req, input int exp_lat, input int lim);
        int lat;
        lat = 0;
        while (!nmi_o && lat < lim) begin
            @(negedge clk);
            lat++;
        end
        chk(req, nmi_o ? lat : -1, exp_lat);
        @(negedge clk);
        chk("R10", int'(nmi_o), 0);
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int lat, len, h, nm, tot, rl, nl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1", int'(cpu_rst_o), 0);
        chk("R1", int'(nmi_o), 0);
        chk("R1", int'(ctl_o), 0);

        // R2 field write/readback
        wr_ctl(8'hC5);
        chk("R2", int'(ctl_o), 8'hC5);
        wr_ctl(8'h00);

        // R3 sweep: both lines, all modes, both edges
        for (int ln = 0; ln < 2; ln++) begin
            for (int m = 0; m < 4; m++) begin
                wr_ctl(8'(m << (2 * ln)));
                set_hs(ln, 1'b1);
                meas_rst("R3", m[1] ? 3 : -1, 12);
                set_hs(ln, 1'b0);
                meas_rst("R3", m[0] ? 3 : -1, 12);
            end
        end

        // R5 software reset; R4 retrigger by line A (mode 11)
        wr_ctl(8'h13);
        lat = 0;
        while (!cpu_rst_o && lat < 12) begin
            @(negedge clk);
            lat++;
        end
        chk("R5", lat, 1);
        len = 0;
        while (cpu_rst_o && len < 100) begin
            len++;
            if (len == 5) hs_a = 1'b1;
            @(negedge clk);
        end
        chk("R4", len, 23);
        chk("R5", int'(ctl_o), 8'h03);
        wr_ctl(8'h00);
        hs_a = 1'b0;
        idle(12, h, nm);
        chk("R3", h, 0);

        // R6 watchdog serviced, disabled, then expiring
        wr_ctl(8'h20);
        tot = 0;
        for (int k = 0; k < 5; k++) begin
            idle(40, h, nm);
            tot += h;
            kick();
        end
        chk("R6", tot, 0);
        wr_ctl(8'h00);
        idle(100, h, nm);
        chk("R6", h, 0);
        wr_ctl(8'h2C);
        meas_rst("R6", 64, 80);
        chk("R6", int'(ctl_o), 8'h0C);
        wr_ctl(8'h00);

        // R7 RTC routed to reset, then to NMI
        rtc = 1'b1;
        meas_rst("R7", 3, 12);
        rtc = 1'b0;
        idle(12, h, nm);
        chk("R7", nm, 0);
        wr_ctl(8'h40);
        rtc = 1'b1;
        meas_nmi("R7", 3, 12);
        chk("R7", int'(cpu_rst_o), 0);
        rtc = 1'b0;
        idle(12, h, nm);
        chk("R7", h, 0);

        // R8 button
        wr_ctl(8'h80);
        btn = 1'b1;
        meas_nmi("R8", 6, 12);
        idle(12, h, nm);
        chk("R8", nm, 0);
        btn = 1'b0;
        idle(12, h, nm);
        chk("R8", nm, 0);
        wr_ctl(8'h00);
        btn = 1'b1;
        idle(12, h, nm);
        chk("R8", nm, 0);
        btn = 1'b0;
        idle(12, h, nm);
        wr_ctl(8'h80);
        btn = 1'b1;
        idle(2, h, nm);
        btn = 1'b0;
        idle(12, h, tot);
        chk("R8", nm + tot, 0);

        // Concurrency: line A reset and RTC NMI in the same cycle (R3, R7)
        wr_ctl(8'h42);
        hs_a = 1'b1;
        rtc = 1'b1;
        rl = -1; nl = -1;
        for (int s = 1; s <= 10; s++) begin
            @(negedge clk);
            if (cpu_rst_o && rl < 0) rl = s;
            if (nmi_o && nl < 0) nl = s;
        end
        chk("R3", rl, 3);
        chk("R7", nl, 3);
        idle(20, h, nm);
        hs_a = 1'b0;
        rtc = 1'b0;
        idle(12, h, nm);
        chk("R3", h, 0);

        // R10 button and RTC NMI merged into one pulse
        wr_ctl(8'hC0);
        btn = 1'b1;
        idle(3, h, tot);
        rtc = 1'b1;
        idle(12, h, nm);
        chk("R10", nm + tot, 1);
        btn = 1'b0;
        rtc = 1'b0;
        idle(12, h, nm);

        // R9 version write
        wr_ctl(8'hEE);
        ver_wr = 1'b1;
        @(negedge clk);
        ver_wr = 1'b0;
        chk("R9", int'(ctl_o), 0);
        meas_rst("R9", 0, 12);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule